// File: doc/BRIEF.md
# Memory Ordering Violation Detector

This block watches the load queue of an out-of-order core for loads that obtained their data too early. When a store, or a load, finishes address generation, the requester hands the block that instruction's address, kind and the load-queue slot it was assigned. The block then walks the younger load-queue slots one per cycle, up to a snapshot of the tail pointer. It compares each slot's effective address with the probe address at a coarse region granularity.

A single violator register keeps the oldest load found to have passed an older memory operation. When a scan finds a load older than the held violator, or finds one while none is held, that load replaces the held one. The requester then sees a fault on the completion pulse, and an event counter advances. A pipeline squash clears the violator when the squash point is older than it. The consumer of the violator reads it with a single read-and-clear strobe.

Top module: `mem_order_detector`

## Requirements
- R1: After reset, busy_o, done_o, fault_o and viol_valid_o are 0 and viol_cnt_o is 0.
- R2: A load-queue slot matches the probe only when its address-valid bit is 1 and its address bits [ADDR_W-1:8] equal those of the probe; bits [7:0] are not compared.
- R3: For a store (req_store_i = 1), the scan starts at req_idx_i and steps upward modulo LQ_DEPTH, stopping before the slot equal to lq_tail_i as sampled at acceptance. The scan runs whatever ld_blocked_i and req_faulted_i are.
- R4: For a load (req_store_i = 0), the scan starts at the slot after req_idx_i (modulo LQ_DEPTH), so the load's own slot is never compared.
- R5: A scan examines one slot per cycle and holds busy_o high while it runs. done_o is a one-cycle pulse, and busy_o and done_o are never high together. If a request is accepted at edge E0 and the scan examines k slots, done_o is high in the cycle after edge Ek. When the scan range is empty, done_o is high in the cycle after E0.
- R6: The scan stops at the first matching slot. If no violator is held, or the slot's sequence number is smaller than the held one, the slot's index and sequence number become the violator, and fault_o is high together with done_o.
- R7: When the first matching slot's sequence number is not smaller than the held violator's, the scan stops, fault_o stays 0, and the violator and counter do not change.
- R8: viol_cnt_o increases by exactly one for every recorded violator and changes at no other time except reset.
- R9: A squash_i whose squash_seq_i is smaller than the held violator's sequence number clears viol_valid_o on the next cycle; a squash with an equal or larger number leaves it held.
- R10: viol_idx_o and viol_seq_o present the held violator in the same cycle that viol_rd_i is high, and viol_valid_o is 0 from the next cycle on.
- R11: A load request with ld_blocked_i or req_faulted_i high performs no scan. It produces done_o in the next cycle with fault_o 0 and the violator unchanged.
- R12: req_valid_i is ignored while busy_o is high: such a request starts no scan, produces no done_o and cannot record a violator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Executing memory instruction presented |
| req_store_i | input | 1 | 1 = store, 0 = load |
| req_idx_i | input | IDX_W | Load-queue index recorded for the instruction |
| req_addr_i | input | ADDR_W | Effective address of the instruction |
| req_faulted_i | input | 1 | Load address generation faulted |
| ld_blocked_i | input | 1 | Loads currently blocked |
| lq_tail_i | input | IDX_W | Load-queue tail pointer |
| lq_addr_i | input | LQ_DEPTH*ADDR_W | Effective address per slot, slot i at bits [i*ADDR_W +: ADDR_W] |
| lq_addr_vld_i | input | LQ_DEPTH | Address-valid bit per slot |
| lq_seq_i | input | LQ_DEPTH*SEQ_W | Sequence number per slot, slot i at bits [i*SEQ_W +: SEQ_W] |
| squash_i | input | 1 | Squash strobe |
| squash_seq_i | input | SEQ_W | Sequence number of the squash point |
| viol_rd_i | input | 1 | Read-and-clear of the violator |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | Scan or skipped request complete |
| fault_o | output | 1 | Violation fault, valid with done_o |
| viol_valid_o | output | 1 | A violator is held |
| viol_idx_o | output | IDX_W | Load-queue index of the held violator |
| viol_seq_o | output | SEQ_W | Sequence number of the held violator |
| viol_cnt_o | output | CNT_W | Recorded violation count |

## Verification
The assertions check on every cycle that busy and done exclude each other and that a fault appears only with done. They also check that each fault coincides with a held violator that is older than the previous one, and with a single counter step. Whenever no scan is active they check that the violator moves only on a read or an older-than squash. The scan range itself — the wrap-around, skipping a load's own slot, coarse address matching, invalid slots and the latency per examined slot — depends on load-queue contents. Only the bench's scenarios, checked against its behavioural model, can show it.

// File: rtl/mem_order_pkg.sv
package mem_order_pkg;

  typedef enum logic {
    KIND_LOAD  = 1'b0,
    KIND_STORE = 1'b1
  } mem_kind_e;

  typedef enum logic [1:0] {
    STEP_CONT,
    STEP_RECORD,
    STEP_YIELD,
    STEP_EXHAUST
  } scan_step_e;

endpackage

// File: rtl/mem_order_region_cmp.sv
module mem_order_region_cmp #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned REGION_LSB = 8
) (
  input  logic [ADDR_W-1:0] probe_addr_i,
  input  logic [ADDR_W-1:0] entry_addr_i,
  input  logic              entry_vld_i,
  output logic              hit_o
);

  logic [ADDR_W-REGION_LSB-1:0] probe_region;
  logic [ADDR_W-REGION_LSB-1:0] entry_region;

  assign probe_region = probe_addr_i[ADDR_W-1:REGION_LSB];
  assign entry_region = entry_addr_i[ADDR_W-1:REGION_LSB];
  assign hit_o        = entry_vld_i && (probe_region == entry_region);

endmodule

// File: rtl/mem_order_scan_ctrl.sv
module mem_order_scan_ctrl
  import mem_order_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_store_i,
  input  logic [IDX_W-1:0]  req_idx_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_faulted_i,
  input  logic              ld_blocked_i,
  input  logic [IDX_W-1:0]  lq_tail_i,
  input  logic              hit_i,
  input  logic              older_ok_i,
  output logic [IDX_W-1:0]  cur_idx_o,
  output logic [ADDR_W-1:0] probe_addr_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              fault_o,
  output logic              record_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  function automatic logic [IDX_W-1:0] ring_step(input logic [IDX_W-1:0] idx);
    return (idx == LAST_IDX) ? '0 : idx + 1'b1;
  endfunction

  mem_kind_e         kind;
  logic [IDX_W-1:0]  start_idx;
  logic              skip_req;
  logic              accept;
  scan_step_e        step_kind;

  logic              busy_q;
  logic              done_q;
  logic              fault_q;
  logic [IDX_W-1:0]  cur_q;
  logic [IDX_W-1:0]  tail_q;
  logic [ADDR_W-1:0] addr_q;

  assign kind      = mem_kind_e'(req_store_i);
  assign start_idx = (kind == KIND_STORE) ? req_idx_i : ring_step(req_idx_i);
  assign skip_req  = (kind == KIND_LOAD) && (req_faulted_i || ld_blocked_i);
  assign accept    = req_valid_i && !busy_q;

  always_comb begin
    step_kind = STEP_CONT;
    if (busy_q) begin
      if (hit_i) begin
        step_kind = older_ok_i ? STEP_RECORD : STEP_YIELD;
      end else if (ring_step(cur_q) == tail_q) begin
        step_kind = STEP_EXHAUST;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      cur_q   <= '0;
      tail_q  <= '0;
      addr_q  <= '0;
    end else begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      if (busy_q) begin
        unique case (step_kind)
          STEP_CONT: cur_q <= ring_step(cur_q);
          STEP_RECORD: begin
            busy_q  <= 1'b0;
            done_q  <= 1'b1;
            fault_q <= 1'b1;
          end
          default: begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        endcase
      end else if (accept) begin
        if (skip_req || (start_idx == lq_tail_i)) begin
          done_q <= 1'b1;
        end else begin
          busy_q <= 1'b1;
          cur_q  <= start_idx;
          tail_q <= lq_tail_i;
          addr_q <= req_addr_i;
        end
      end
    end
  end

  assign cur_idx_o    = cur_q;
  assign probe_addr_o = addr_q;
  assign busy_o       = busy_q;
  assign done_o       = done_q;
  assign fault_o      = done_q && fault_q;
  assign record_o     = (step_kind == STEP_RECORD);

endmodule

// File: rtl/mem_order_violator.sv
module mem_order_violator #(
  parameter int unsigned IDX_W = 3,
  parameter int unsigned SEQ_W = 16,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             record_i,
  input  logic [IDX_W-1:0] cand_idx_i,
  input  logic [SEQ_W-1:0] cand_seq_i,
  input  logic             rd_i,
  input  logic             squash_i,
  input  logic [SEQ_W-1:0] squash_seq_i,
  output logic             older_ok_o,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [SEQ_W-1:0] seq_o,
  output logic [CNT_W-1:0] cnt_o
);

  logic             valid_q;
  logic [IDX_W-1:0] idx_q;
  logic [SEQ_W-1:0] seq_q;
  logic [CNT_W-1:0] cnt_q;
  logic             clear;

  // oldest wins: replace only with a strictly smaller sequence number
  assign older_ok_o = !valid_q || (cand_seq_i < seq_q);
  assign clear      = rd_i || (squash_i && (squash_seq_i < seq_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      idx_q   <= '0;
      seq_q   <= '0;
      cnt_q   <= '0;
    end else if (record_i) begin
      valid_q <= 1'b1;
      idx_q   <= cand_idx_i;
      seq_q   <= cand_seq_i;
      cnt_q   <= cnt_q + 1'b1;
    end else if (clear) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign idx_o   = idx_q;
  assign seq_o   = seq_q;
  assign cnt_o   = cnt_q;

endmodule

// File: rtl/mem_order_detector.sv
module mem_order_detector #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LQ_DEPTH   = 8,
  parameter int unsigned SEQ_W      = 16,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned REGION_LSB = 8,
  localparam int unsigned IDX_W     = (LQ_DEPTH > 1) ? $clog2(LQ_DEPTH) : 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         req_valid_i,
  input  logic                         req_store_i,
  input  logic [IDX_W-1:0]             req_idx_i,
  input  logic [ADDR_W-1:0]            req_addr_i,
  input  logic                         req_faulted_i,
  input  logic                         ld_blocked_i,
  input  logic [IDX_W-1:0]             lq_tail_i,
  input  logic [LQ_DEPTH*ADDR_W-1:0]   lq_addr_i,
  input  logic [LQ_DEPTH-1:0]          lq_addr_vld_i,
  input  logic [LQ_DEPTH*SEQ_W-1:0]    lq_seq_i,
  input  logic                         squash_i,
  input  logic [SEQ_W-1:0]             squash_seq_i,
  input  logic                         viol_rd_i,
  output logic                         busy_o,
  output logic                         done_o,
  output logic                         fault_o,
  output logic                         viol_valid_o,
  output logic [IDX_W-1:0]             viol_idx_o,
  output logic [SEQ_W-1:0]             viol_seq_o,
  output logic [CNT_W-1:0]             viol_cnt_o
);

  logic [ADDR_W-1:0] ent_addr [LQ_DEPTH];
  logic [SEQ_W-1:0]  ent_seq  [LQ_DEPTH];

  for (genvar g = 0; g < LQ_DEPTH; g++) begin : g_unpack
    assign ent_addr[g] = lq_addr_i[g*ADDR_W +: ADDR_W];
    assign ent_seq[g]  = lq_seq_i[g*SEQ_W +: SEQ_W];
  end

  logic [IDX_W-1:0]  cur_idx;
  logic [ADDR_W-1:0] probe_addr;
  logic              hit;
  logic              older_ok;
  logic              record;

  mem_order_scan_ctrl #(
    .DEPTH  (LQ_DEPTH),
    .IDX_W  (IDX_W),
    .ADDR_W (ADDR_W)
  ) u_scan (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_valid_i   (req_valid_i),
    .req_store_i   (req_store_i),
    .req_idx_i     (req_idx_i),
    .req_addr_i    (req_addr_i),
    .req_faulted_i (req_faulted_i),
    .ld_blocked_i  (ld_blocked_i),
    .lq_tail_i     (lq_tail_i),
    .hit_i         (hit),
    .older_ok_i    (older_ok),
    .cur_idx_o     (cur_idx),
    .probe_addr_o  (probe_addr),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .fault_o       (fault_o),
    .record_o      (record)
  );

  mem_order_region_cmp #(
    .ADDR_W     (ADDR_W),
    .REGION_LSB (REGION_LSB)
  ) u_cmp (
    .probe_addr_i (probe_addr),
    .entry_addr_i (ent_addr[cur_idx]),
    .entry_vld_i  (lq_addr_vld_i[cur_idx]),
    .hit_o        (hit)
  );

  mem_order_violator #(
    .IDX_W (IDX_W),
    .SEQ_W (SEQ_W),
    .CNT_W (CNT_W)
  ) u_viol (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .record_i     (record),
    .cand_idx_i   (cur_idx),
    .cand_seq_i   (ent_seq[cur_idx]),
    .rd_i         (viol_rd_i),
    .squash_i     (squash_i),
    .squash_seq_i (squash_seq_i),
    .older_ok_o   (older_ok),
    .valid_o      (viol_valid_o),
    .idx_o        (viol_idx_o),
    .seq_o        (viol_seq_o),
    .cnt_o        (viol_cnt_o)
  );

endmodule

// File: rtl/mem_order_detector_chk.sv
module mem_order_detector_chk #(
  parameter int unsigned IDX_W = 3,
  parameter int unsigned SEQ_W = 16,
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             squash_i,
  input logic [SEQ_W-1:0] squash_seq_i,
  input logic             viol_rd_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             fault_o,
  input logic             viol_valid_o,
  input logic [IDX_W-1:0] viol_idx_o,
  input logic [SEQ_W-1:0] viol_seq_o,
  input logic [CNT_W-1:0] viol_cnt_o
);

  // R5
  busy_done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));

  // R5
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R6
  fault_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> done_o);

  // R6
  fault_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> viol_valid_o);

  // R6
  oldest_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (!$past(viol_valid_o) || (viol_seq_o < $past(viol_seq_o))));

  // R8
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (viol_cnt_o == CNT_W'($past(viol_cnt_o) + 1'b1)));

  // R7
  no_fault_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !fault_o) |-> $stable(viol_cnt_o));

  // R10
  read_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_rd_i && !busy_o) |=> !viol_valid_o);

  // R9
  squash_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (squash_i && !busy_o && viol_valid_o && (squash_seq_i < viol_seq_o)) |=> !viol_valid_o);

  // R12
  idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !viol_rd_i && !squash_i) |=>
      ($stable(viol_valid_o) && $stable(viol_idx_o) && $stable(viol_seq_o) && $stable(viol_cnt_o)));

endmodule

bind mem_order_detector mem_order_detector_chk #(
  .IDX_W (IDX_W),
  .SEQ_W (SEQ_W),
  .CNT_W (CNT_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .squash_i     (squash_i),
  .squash_seq_i (squash_seq_i),
  .viol_rd_i    (viol_rd_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .fault_o      (fault_o),
  .viol_valid_o (viol_valid_o),
  .viol_idx_o   (viol_idx_o),
  .viol_seq_o   (viol_seq_o),
  .viol_cnt_o   (viol_cnt_o)
);

// File: tb/mem_order_detector_tb_top.sv
module mem_order_detector_tb_top;

  localparam int D = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_store = 1'b0;
  logic [2:0]  req_idx = '0;
  logic [31:0] req_addr = '0;
  logic        req_faulted = 1'b0;
  logic        ld_blocked = 1'b0;
  logic [2:0]  lq_tail = '0;
  logic        squash = 1'b0;
  logic [15:0] squash_seq = '0;
  logic        viol_rd = 1'b0;

  logic [31:0] b_addr [D];
  logic        b_vld  [D];
  logic [15:0] b_seq  [D];

  logic [D*32-1:0] lq_addr;
  logic [D-1:0]    lq_vld;
  logic [D*16-1:0] lq_seq;

  always_comb begin
    for (int i = 0; i < D; i++) begin
      lq_addr[i*32 +: 32] = b_addr[i];
      lq_vld[i]           = b_vld[i];
      lq_seq[i*16 +: 16]  = b_seq[i];
    end
  end

  logic        busy, done, fault, viol_valid;
  logic [2:0]  viol_idx;
  logic [15:0] viol_seq;
  logic [15:0] viol_cnt;

  mem_order_detector dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .req_valid_i   (req_valid),
    .req_store_i   (req_store),
    .req_idx_i     (req_idx),
    .req_addr_i    (req_addr),
    .req_faulted_i (req_faulted),
    .ld_blocked_i  (ld_blocked),
    .lq_tail_i     (lq_tail),
    .lq_addr_i     (lq_addr),
    .lq_addr_vld_i (lq_vld),
    .lq_seq_i      (lq_seq),
    .squash_i      (squash),
    .squash_seq_i  (squash_seq),
    .viol_rd_i     (viol_rd),
    .busy_o        (busy),
    .done_o        (done),
    .fault_o       (fault),
    .viol_valid_o  (viol_valid),
    .viol_idx_o    (viol_idx),
    .viol_seq_o    (viol_seq),
    .viol_cnt_o    (viol_cnt)
  );

  always #4 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  string phase = "R1";

  task automatic chk(input string tag, input longint got, input longint exp);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  // behavioural reference model
  bit m_busy, m_done, m_fault, m_vv, m_hit;
  int m_remain, m_vidx, m_vseq, m_cnt, m_hidx, m_hseq;
  int w_j, w_k, w_start;
  bit w_rec, w_done;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_fault = 0; m_vv = 0; m_hit = 0;
      m_remain = 0; m_vidx = 0; m_vseq = 0; m_cnt = 0; m_hidx = 0; m_hseq = 0;
    end else begin
      w_rec = 0; w_done = 0;
      if (m_busy) begin
        m_remain--;
        if (m_remain == 0) begin
          m_busy = 0;
          w_done = 1;
          if (m_hit && (!m_vv || m_hseq < m_vseq)) w_rec = 1;
        end
      end else if (req_valid) begin
        if (!req_store && (req_faulted || ld_blocked)) begin
          w_done = 1;
        end else begin
          w_start = req_store ? int'(req_idx) : (int'(req_idx) + 1) % D;
          w_j = w_start; w_k = 0; m_hit = 0;
          while (w_j != int'(lq_tail)) begin
            w_k++;
            if (b_vld[w_j] && ((b_addr[w_j] >> 8) == (req_addr >> 8))) begin
              m_hit = 1; m_hidx = w_j; m_hseq = int'(b_seq[w_j]);
              break;
            end
            w_j = (w_j + 1) % D;
          end
          if (w_k == 0) w_done = 1;
          else begin m_busy = 1; m_remain = w_k; end
        end
      end
      if (w_rec) begin
        m_vv = 1; m_vidx = m_hidx; m_vseq = m_hseq; m_cnt = (m_cnt + 1) % 65536;
      end else if (viol_rd || (squash && int'(squash_seq) < m_vseq)) begin
        m_vv = 0;
      end
      m_done = w_done;
      m_fault = w_rec;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk({phase, " R5 busy"}, busy, m_busy);
      chk({phase, " R5 done"}, done, m_done);
      chk({phase, " R6 fault"}, fault, m_fault);
      chk({phase, " R6 viol_valid"}, viol_valid, m_vv);
      if (m_vv) begin
        chk({phase, " R6 viol_idx"}, viol_idx, m_vidx);
        chk({phase, " R6 viol_seq"}, viol_seq, m_vseq);
      end
      chk({phase, " R8 viol_cnt"}, viol_cnt, m_cnt);
    end
  end

  task automatic set_ent(input int i, input bit v, input logic [31:0] a, input int s);
    b_vld[i] = v; b_addr[i] = a; b_seq[i] = 16'(s);
  endtask

  task automatic run_req(input bit st, input int idx, input logic [31:0] a, input int tl,
                         input bit flt, input bit blk, output bit f, output int lat);
    @(negedge clk);
    req_valid = 1; req_store = st; req_idx = 3'(idx); req_addr = a;
    lq_tail = 3'(tl); req_faulted = flt; ld_blocked = blk;
    @(negedge clk);
    req_valid = 0; req_faulted = 0; ld_blocked = 0;
    lat = 1;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    f = fault;
  endtask

  task automatic pulse_rd();
    @(negedge clk); viol_rd = 1;
    @(negedge clk); viol_rd = 0;
  endtask

  task automatic pulse_squash(input int s);
    @(negedge clk); squash = 1; squash_seq = 16'(s);
    @(negedge clk); squash = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    bit f;
    int lat;
    for (int i = 0; i < D; i++) set_ent(i, 0, 32'h0, 100 + i);
    repeat (3) @(negedge clk);
    chk("R1 busy reset", busy, 0);
    chk("R1 valid reset", viol_valid, 0);
    chk("R1 cnt reset", viol_cnt, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 done after reset", done, 0);

    // R2 R3: invalid slot skipped, low bits ignored
    phase = "R2";
    set_ent(2, 0, 32'h2300, 20);
    set_ent(3, 1, 32'h23FF, 30);
    run_req(1, 2, 32'h2300, 6, 0, 0, f, lat);
    chk("R2 fault on region match", f, 1);
    chk("R5 latency two slots", lat, 3);
    chk("R6 viol_idx", viol_idx, 3);
    chk("R6 viol_seq", viol_seq, 30);
    chk("R8 cnt after first", viol_cnt, 1);

    // R10 read-and-clear
    phase = "R10";
    @(negedge clk); viol_rd = 1;
    chk("R10 idx visible during read", viol_idx, 3);
    @(negedge clk); viol_rd = 0;
    chk("R10 cleared after read", viol_valid, 0);

    // R4 load skips own slot
    phase = "R4";
    set_ent(4, 1, 32'h5000, 40);
    set_ent(5, 1, 32'h5010, 41);
    run_req(0, 3, 32'h2300, 6, 0, 0, f, lat);
    chk("R4 own slot not compared", f, 0);
    chk("R4 latency", lat, 3);

    // R3 wrap
    phase = "R3";
    set_ent(6, 1, 32'h1000, 60);
    set_ent(7, 0, 32'h7700, 70);
    set_ent(0, 1, 32'h8800, 80);
    set_ent(1, 1, 32'h7700, 12);
    run_req(1, 6, 32'h7711, 2, 0, 0, f, lat);
    chk("R3 wrap fault", f, 1);
    chk("R3 wrap viol_idx", viol_idx, 1);
    chk("R5 wrap latency", lat, 5);

    // R7 younger match yields
    phase = "R7";
    set_ent(4, 1, 32'h9900, 40);
    run_req(1, 4, 32'h99AA, 6, 0, 0, f, lat);
    chk("R7 no fault for younger", f, 0);
    chk("R7 viol_seq kept", viol_seq, 12);
    chk("R7 cnt kept", viol_cnt, 2);

    // R6 older match replaces
    phase = "R6";
    set_ent(4, 1, 32'h9900, 5);
    run_req(1, 4, 32'h99AA, 6, 0, 0, f, lat);
    chk("R6 older fault", f, 1);
    chk("R6 replaced seq", viol_seq, 5);
    chk("R6 replaced idx", viol_idx, 4);
    chk("R8 cnt three", viol_cnt, 3);

    // R9 squash
    phase = "R9";
    pulse_squash(9);
    chk("R9 squash younger keeps", viol_valid, 1);
    pulse_squash(5);
    chk("R9 squash equal keeps", viol_valid, 1);
    pulse_squash(3);
    chk("R9 squash older clears", viol_valid, 0);

    // R11 blocked or faulted loads
    phase = "R11";
    run_req(0, 3, 32'h9900, 6, 0, 1, f, lat);
    chk("R11 blocked load no fault", f, 0);
    chk("R11 blocked latency", lat, 1);
    run_req(0, 3, 32'h9900, 6, 1, 0, f, lat);
    chk("R11 faulted load no fault", f, 0);
    chk("R11 valid unchanged", viol_valid, 0);
    run_req(1, 4, 32'h9900, 6, 0, 1, f, lat);
    chk("R3 store scans when blocked", f, 1);
    chk("R8 cnt four", viol_cnt, 4);
    pulse_rd();

    // R12 request while busy ignored
    phase = "R12";
    for (int i = 0; i < D; i++) set_ent(i, 1, 32'h1100, 1);
    @(negedge clk);
    req_valid = 1; req_store = 1; req_idx = 3'd0; req_addr = 32'h3300; lq_tail = 3'd7;
    @(negedge clk); req_valid = 0;
    @(negedge clk);
    req_valid = 1; req_store = 0; req_idx = 3'd0; req_addr = 32'h1100;
    @(negedge clk); req_valid = 0;
    lat = 3;
    while (!done && lat < 100) begin @(negedge clk); lat++; end
    chk("R12 long scan no fault", fault, 0);
    chk("R5 seven-slot latency", lat, 8);
    repeat (3) @(negedge clk);
    chk("R12 no second scan", busy, 0);
    chk("R12 no violator from ignored", viol_valid, 0);

    // R5 empty range
    phase = "R5";
    run_req(1, 5, 32'h1100, 5, 0, 0, f, lat);
    chk("R5 empty range fault", f, 0);
    chk("R5 empty range latency", lat, 1);
    run_req(0, 7, 32'h1100, 0, 0, 0, f, lat);
    chk("R4 load at last slot empty", lat, 1);

    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule